// File: doc/BRIEF.md
# Programmable Peripheral Window Decoder

This block places a 16 KB peripheral window anywhere in a 28-bit address space and reports, for every bus access, whether the access falls inside it. One 16-bit control word sets the window. Its top bit turns the window on. Its low fourteen bits give the base and line up one-to-one with address bits 27 down to 14.

Software reaches the control word over a small register port at one fixed address, and only with full 16-bit accesses. The rules allow only two whole-word values: 16'h8FFB to switch the window on, and 16'h0000 to switch it off. Any other value is still stored, but it also raises a sticky flag so the misuse can be seen. The hit output is registered, so downstream decode logic sees a clean signal one cycle after the access.

Top module: `ppw_window_top`

## Requirements
- R1: After a synchronous reset the control word is 16'h0000, `win_hit` is 0, `bad_write` is 0, and a read returns 16'h0000.
- R2: A read (`reg_valid`=1, `reg_write`=0, `reg_wide`=1, `reg_addr` equal to the fixed address, default 28'hFFFF064) puts the control word on `reg_rdata` one clock later, with bit 14 always 0.
- R3: Bit 14 of a written value is discarded: writing 16'hCFFB reads back as 16'h8FFB.
- R4: Bit 15 of the control word enables the window. While it is 0, `win_hit` stays 0 for every access.
- R5: An access hits when `acc_addr[27:14]` equals control bits [13:0]. With 16'h8FFB the window spans 28'h3FEC000 to 28'h3FEFFFF inclusive, and the addresses just outside it miss.
- R6: `win_hit` is registered. It is high in the cycle after an access with `acc_valid`=1 that hits, and it is never high after a cycle with `acc_valid`=0.
- R7: A register write is used by the decoder for accesses presented in the cycle right after the write edge.
- R8: A full-width write whose raw value is neither 16'h8FFB nor 16'h0000 is stored as written (bit 14 cleared) and sets `bad_write`. The flag stays set until reset.
- R9: A write with `reg_wide`=0 leaves the control word unchanged. A read with `reg_wide`=0 returns 16'h0000.
- R10: A write or read with `reg_addr` different from the fixed address has no effect on the control word, and the read returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = full 16-bit access; 0 = narrow lane access |
| reg_addr | input | 28 | Register access address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| acc_valid | input | 1 | Bus access to decode is valid |
| acc_addr | input | 28 | Bus access address |
| win_hit | output | 1 | Registered window hit |
| bad_write | output | 1 | Sticky flag for a write of a value outside the allowed pair |

## Verification
The decoder is driven with addresses at the lowest and highest byte of the window and with the addresses one byte below and one byte above it. These cases separate a correct 14-bit compare from an off-by-one in the compare or a wrong bit slice. The same in-window address is also presented with the window disabled and with `acc_valid` low, which isolates the enable bit from the valid qualifier. Register accesses cover a legal value, a value with the reserved bit set, an illegal base, narrow-lane accesses and accesses to the wrong address. Together they separate storing from flagging from ignoring. A back-to-back write followed by an access in the next cycle pins down when a new setting takes effect.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  // Bit roles inside the control word
  localparam int EN_POS  = 15;
  localparam int RSV_POS = 14;

  // The two whole-word values the rules allow
  localparam logic [15:0] WIN_ON_VAL  = 16'h8FFB;
  localparam logic [15:0] WIN_OFF_VAL = 16'h0000;

  function automatic logic val_allowed(input logic [15:0] v);
    return (v == WIN_ON_VAL) || (v == WIN_OFF_VAL);
  endfunction
endpackage

// File: rtl/ppw_ctrl_reg.sv
module ppw_ctrl_reg #(
  parameter int DATA_W = 16,
  parameter int RSV_BIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              bad_q
);
  localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(1) << RSV_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      bad_q  <= 1'b0;
    end else if (wr_fire) begin
      ctrl_q <= wdata & ~RSV_MASK;
      if (!ppw_pkg::val_allowed(wdata)) bad_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ppw_rd_port.sv
module ppw_rd_port #(
  parameter int DATA_W = 16,
  parameter int RSV_BIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(1) << RSV_BIT;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_fire ? (ctrl_q & ~RSV_MASK) : '0;
  end
endmodule

// File: rtl/ppw_window_cmp.sv
module ppw_window_cmp #(
  parameter int ADDR_W   = 28,
  parameter int BASE_LSB = 14,
  localparam int BASE_W  = ADDR_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [BASE_W-1:0] base,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit_q
);
  logic [BASE_W-1:0] bit_eq;

  for (genvar i = 0; i < BASE_W; i++) begin : g_eq
    assign bit_eq[i] = (acc_addr[BASE_LSB+i] == base[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= acc_valid && enable && (&bit_eq);
  end
endmodule

// File: rtl/ppw_window_top.sv
module ppw_window_top #(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 16,
  parameter int BASE_LSB = 14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 28'hFFFF064
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_wide,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              win_hit,
  output logic              bad_write
);
  localparam int BASE_W = ADDR_W - BASE_LSB;

  logic              addr_match;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] ctrl_q;

  assign addr_match = reg_valid && reg_wide && (reg_addr == CTRL_ADDR);
  assign wr_fire    = addr_match && reg_write;
  assign rd_fire    = addr_match && !reg_write;

  ppw_ctrl_reg #(.DATA_W(DATA_W), .RSV_BIT(ppw_pkg::RSV_POS)) u_reg (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .bad_q(bad_write)
  );

  ppw_rd_port #(.DATA_W(DATA_W), .RSV_BIT(ppw_pkg::RSV_POS)) u_rd (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .ctrl_q(ctrl_q), .rdata(reg_rdata)
  );

  ppw_window_cmp #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_cmp (
    .clk(clk), .rst(rst), .enable(ctrl_q[ppw_pkg::EN_POS]),
    .base(ctrl_q[BASE_W-1:0]), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .hit_q(win_hit)
  );
endmodule

// File: rtl/ppw_window_chk.sv
module ppw_window_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_valid,
  input logic              reg_write,
  input logic              reg_wide,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              acc_valid,
  input logic              win_hit,
  input logic              bad_write,
  input logic [DATA_W-1:0] ctrl_q
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !win_hit && !bad_write));

  // R2
  rsv_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[ppw_pkg::RSV_POS] == 1'b0);

  // R4
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> $past(ctrl_q[ppw_pkg::EN_POS]));

  // R6
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> $past(acc_valid));

  // R8
  bad_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bad_write |=> bad_write);

  // R9
  narrow_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_write && !reg_wide) |=> $stable(ctrl_q));
endmodule

bind ppw_window_top ppw_window_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_wide(reg_wide), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
  .win_hit(win_hit), .bad_write(bad_write), .ctrl_q(ctrl_q)
);

// File: tb/sim_ppw_window_top.sv
module sim_ppw_window_top;
  localparam logic [27:0] CA = 28'hFFFF064;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_valid, reg_write, reg_wide;
  logic [27:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        acc_valid;
  logic [27:0] acc_addr;
  logic        win_hit, bad_write;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ppw_window_top u0 (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .win_hit(win_hit), .bad_write(bad_write)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_valid = 0; reg_write = 0; reg_wide = 1; reg_addr = CA; reg_wdata = '0;
    acc_valid = 0; acc_addr = '0;
  endtask

  task automatic reg_wr(input logic [27:0] a, input logic [15:0] d, input logic wide);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic reg_rd(input logic [27:0] a, input logic wide, output logic [15:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_wide = wide; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    idle();
  endtask

  task automatic probe(input logic v, input logic [27:0] a, output logic h);
    @(negedge clk);
    acc_valid = v; acc_addr = a;
    @(negedge clk);
    h = win_hit;
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle();
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic h;
    do_reset();
    check(bad_write == 0 && win_hit == 0, "R1 flags", {30'b0, bad_write, win_hit}, 0);
    reg_rd(CA, 1, d);
    check(d == 16'h0000, "R1 read", d, 16'h0000);
    probe(1, 28'h0000000, h);
    check(h == 0, "R4 disabled at reset", h, 0);
  endtask

  task automatic t_enable_window();
    logic [15:0] d; logic h;
    reg_wr(CA, 16'h8FFB, 1);
    reg_rd(CA, 1, d);
    check(d == 16'h8FFB, "R2 readback", d, 16'h8FFB);
    check(bad_write == 0, "R8 legal value no flag", bad_write, 0);
    probe(1, 28'h3FEC000, h); check(h == 1, "R5 low edge", h, 1);
    probe(1, 28'h3FEFFFF, h); check(h == 1, "R5 high edge", h, 1);
    probe(1, 28'h3FEBFFF, h); check(h == 0, "R5 below", h, 0);
    probe(1, 28'h3FF0000, h); check(h == 0, "R5 above", h, 0);
    probe(0, 28'h3FED123, h); check(h == 0, "R6 invalid access", h, 0);
  endtask

  task automatic t_narrow_and_foreign();
    logic [15:0] d; logic h;
    reg_wr(CA, 16'h0000, 0);
    reg_wr(CA + 28'h2, 16'h0000, 1);
    probe(1, 28'h3FEC010, h);
    check(h == 1, "R9 R10 writes ignored", h, 1);
    reg_rd(CA, 0, d); check(d == 16'h0000, "R9 narrow read", d, 0);
    reg_rd(CA + 28'h2, 1, d); check(d == 16'h0000, "R10 foreign read", d, 0);
    reg_rd(CA, 1, d); check(d == 16'h8FFB, "R9 R10 word kept", d, 16'h8FFB);
  endtask

  task automatic t_timing();
    logic h;
    // write 0000 and present the access in the very next cycle
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_wide = 1; reg_addr = CA; reg_wdata = 16'h0000;
    @(negedge clk);
    idle(); acc_valid = 1; acc_addr = 28'h3FEC000;
    @(negedge clk);
    h = win_hit; idle();
    check(h == 0, "R7 disable next cycle", h, 0);
    check(bad_write == 0, "R8 off value no flag", bad_write, 0);
    probe(1, 28'h3FEE000, h); check(h == 0, "R4 disabled window", h, 0);
  endtask

  task automatic t_reserved();
    logic [15:0] d; logic h;
    reg_wr(CA, 16'hCFFB, 1);
    reg_rd(CA, 1, d); check(d == 16'h8FFB, "R3 reserved dropped", d, 16'h8FFB);
    probe(1, 28'h3FEC000, h); check(h == 1, "R3 window still placed", h, 1);
    check(bad_write == 1, "R8 raw value flagged", bad_write, 1);
  endtask

  task automatic t_illegal();
    logic [15:0] d; logic h;
    do_reset();
    reg_wr(CA, 16'h8001, 1);
    check(bad_write == 1, "R8 flag set", bad_write, 1);
    reg_rd(CA, 1, d); check(d == 16'h8001, "R8 stored", d, 16'h8001);
    probe(1, 28'h0004000, h); check(h == 1, "R8 base used", h, 1);
    reg_wr(CA, 16'h0000, 1);
    check(bad_write == 1, "R8 sticky", bad_write, 1);
    do_reset();
    check(bad_write == 0, "R8 R1 reset clears", bad_write, 0);
  endtask

  initial begin
    rst = 1; idle();
    t_reset();
    t_enable_window();
    t_narrow_and_foreign();
    t_timing();
    t_reserved();
    t_illegal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule